// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Sequencer

This block moves a running PLL from its present feedback divider to a new one without taking the PLL out of lock. It drives the PLL's slowdown and dynamic-ramp controls in a fixed order. It also owns the registers that hold the integer divider N and the two sigma-delta (SDM) fraction fields. A controller supplies a one-cycle start pulse together with the target N and SDM word and the values currently applied. The block then runs the sequence on its own and reports the result with a done pulse and, when the PLL never reports ramp completion, a sticky timeout flag.

The fraction is written in two stages. It goes first into a staging field that the PLL picks up during the ramp. It is copied into the active field only once the ramp is over. When the requested divider equals the one already applied, the block completes at once and leaves every control untouched. The three wait windows are given in microseconds and turned into cycle counts using the clock frequency parameter. The defaults are 1 µs before the N write, 1 µs before the ramp, and 500 µs for the ramp itself.

Top module: `pll_ndiv_ramp_seq`

## Requirements
- R1: Out of reset, slowdown, ramp enable, busy, done and timeout are 0, and the N register, the active SDM field and the staging SDM field all hold 0.
- R2: A start accepted when target N equals current N and target SDM equals current SDM raises done in the next cycle. Slowdown and ramp stay 0, busy stays 0, and the N and both SDM registers keep their values.
- R3: One cycle after any other accepted start, slowdown is 1 and the 15-bit staging SDM field holds the target SDM zero-extended. The active 8-bit SDM field is still unchanged.
- R4: The N register takes the target N exactly PRE_N_US*CLK_MHZ cycles after slowdown rises, while ramp enable is still 0.
- R5: Ramp enable rises exactly PRE_RAMP_US*CLK_MHZ cycles after the N write.
- R6: In the cycle after ramp-done is sampled high while ramping, the active SDM field takes the target SDM and slowdown is still 1. In the following cycle slowdown and ramp enable fall together and done is 1.
- R7: If ramp-done is not seen within RAMP_TMO_US*CLK_MHZ cycles of ramp enable rising, timeout goes to 1 and the active SDM field is written anyway, and the sequence then finishes as in R6. Timeout stays 1 until the next accepted start clears it.
- R8: Busy is 1 from the cycle after an accepted non-trivial start until done. A start pulse seen while busy is ignored, and the run completes with the first target.
- R9: Done is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to move to the target divider |
| tgt_n_i | input | N_W | Target integer feedback divider |
| tgt_sdm_i | input | SDM_W | Target SDM fraction word |
| cur_n_i | input | N_W | Integer divider currently applied |
| cur_sdm_i | input | SDM_W | SDM word currently applied |
| ramp_done_i | input | 1 | Synchronized ramp-complete status from the PLL |
| slow_en_o | output | 1 | Slowdown-using-PLL mode enable |
| ramp_en_o | output | 1 | Dynamic ramp enable |
| sdm_stage_o | output | SDM_STAGE_W | Staging ("new") SDM field |
| sdm_act_o | output | SDM_W | Active SDM field |
| ndiv_o | output | N_W | Integer N register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Ramp-done wait expired during the last run |

## Verification
The embedded properties check the ordering rules on every cycle. Ramp enable is never high without slowdown. N changes only inside slowdown and before the ramp. The active SDM field changes only at the end of the ramp. Slowdown and ramp always fall in the same cycle, done never lasts two cycles, a start while busy leaves the latched target alone, and the wait counter never wraps. The exact lengths of the two settling waits and of the timeout window, the SDM staging values, the skip on an unchanged divider and the clearing of the sticky timeout depend on the sequence of requests, so only the bench scenarios can show them.

// File: rtl/pll_ndiv_ramp_pkg.sv
package pll_ndiv_ramp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRE_N    = 3'd1,
        ST_PRE_RAMP = 3'd2,
        ST_RAMP     = 3'd3,
        ST_EXIT     = 3'd4
    } seq_state_e;

    function automatic int us_to_cycles(input int clk_mhz, input int us);
        return clk_mhz * us;
    endfunction

endpackage

// File: rtl/pll_ndiv_ramp_timer.sv
module pll_ndiv_ramp_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o); // R4

    AST_TMR_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !zero_o); // R5

endmodule

// File: rtl/pll_ndiv_ramp_ctrl.sv
module pll_ndiv_ramp_ctrl
    import pll_ndiv_ramp_pkg::*;
#(
    parameter int N_W         = 8,
    parameter int SDM_W       = 8,
    parameter int SDM_STAGE_W = 15,
    parameter int CNT_W       = 17,
    parameter int PRE_N_CYC   = 200,
    parameter int PRE_RAMP_CYC = 200,
    parameter int RAMP_TMO_CYC = 100000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [N_W-1:0]         tgt_n_i,
    input  logic [SDM_W-1:0]       tgt_sdm_i,
    input  logic [N_W-1:0]         cur_n_i,
    input  logic [SDM_W-1:0]       cur_sdm_i,
    input  logic                   ramp_done_i,
    input  logic                   tmr_zero_i,
    output logic                   tmr_load_o,
    output logic [CNT_W-1:0]       tmr_val_o,
    output logic                   slow_en_o,
    output logic                   ramp_en_o,
    output logic [SDM_STAGE_W-1:0] sdm_stage_o,
    output logic [SDM_W-1:0]       sdm_act_o,
    output logic [N_W-1:0]         ndiv_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   timeout_o
);

    localparam logic [CNT_W-1:0] LD_PRE_N    = CNT_W'(PRE_N_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PRE_RAMP = CNT_W'(PRE_RAMP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RAMP_TMO = CNT_W'(RAMP_TMO_CYC - 1);

    typedef struct packed {
        seq_state_e             state;
        logic                   slow;
        logic                   ramp;
        logic                   done;
        logic                   tmo;
        logic [N_W-1:0]         ndiv;
        logic [SDM_W-1:0]       sdm_act;
        logic [SDM_STAGE_W-1:0] sdm_stage;
        logic [N_W-1:0]         hold_n;
        logic [SDM_W-1:0]       hold_sdm;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  ld_d;
    logic [CNT_W-1:0] ldv_d;
    logic  same_div;

    assign same_div = (tgt_n_i == cur_n_i) && (tgt_sdm_i == cur_sdm_i);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ld_d     = 1'b0;
        ldv_d    = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.tmo = 1'b0;
                    if (same_div) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state     = ST_PRE_N;
                        r_d.slow      = 1'b1;
                        r_d.sdm_stage = SDM_STAGE_W'(tgt_sdm_i);
                        r_d.hold_n    = tgt_n_i;
                        r_d.hold_sdm  = tgt_sdm_i;
                        ld_d          = 1'b1;
                        ldv_d         = LD_PRE_N;
                    end
                end
            end
            ST_PRE_N: begin
                if (tmr_zero_i) begin
                    r_d.ndiv  = r_q.hold_n;
                    r_d.state = ST_PRE_RAMP;
                    ld_d      = 1'b1;
                    ldv_d     = LD_PRE_RAMP;
                end
            end
            ST_PRE_RAMP: begin
                if (tmr_zero_i) begin
                    r_d.ramp  = 1'b1;
                    r_d.state = ST_RAMP;
                    ld_d      = 1'b1;
                    ldv_d     = LD_RAMP_TMO;
                end
            end
            ST_RAMP: begin
                if (ramp_done_i) begin
                    r_d.sdm_act = r_q.hold_sdm;
                    r_d.state   = ST_EXIT;
                end else if (tmr_zero_i) begin
                    r_d.tmo     = 1'b1;
                    r_d.sdm_act = r_q.hold_sdm;
                    r_d.state   = ST_EXIT;
                end
            end
            ST_EXIT: begin
                r_d.slow  = 1'b0;
                r_d.ramp  = 1'b0;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.slow  = 1'b0;
                r_d.ramp  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tmr_load_o  = ld_d;
    assign tmr_val_o   = ldv_d;
    assign slow_en_o   = r_q.slow;
    assign ramp_en_o   = r_q.ramp;
    assign sdm_stage_o = r_q.sdm_stage;
    assign sdm_act_o   = r_q.sdm_act;
    assign ndiv_o      = r_q.ndiv;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = r_q.done;
    assign timeout_o   = r_q.tmo;

    AST_RAMP_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en_o |-> slow_en_o); // R5

    AST_N_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ndiv_o) |-> (slow_en_o && !ramp_en_o)); // R4

    AST_SDM_ACT_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdm_act_o) |-> (ramp_en_o && slow_en_o && !done_o)); // R6

    AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_en_o) |-> ($fell(ramp_en_o) && done_o)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(r_q.hold_n) && $stable(r_q.hold_sdm))); // R8

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !start_i) |=> timeout_o); // R7

endmodule

// File: rtl/pll_ndiv_ramp_seq.sv
module pll_ndiv_ramp_seq
    import pll_ndiv_ramp_pkg::*;
#(
    parameter int N_W         = 8,
    parameter int SDM_W       = 8,
    parameter int SDM_STAGE_W = 15,
    parameter int CLK_MHZ     = 200,
    parameter int PRE_N_US    = 1,
    parameter int PRE_RAMP_US = 1,
    parameter int RAMP_TMO_US = 500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [N_W-1:0]         tgt_n_i,
    input  logic [SDM_W-1:0]       tgt_sdm_i,
    input  logic [N_W-1:0]         cur_n_i,
    input  logic [SDM_W-1:0]       cur_sdm_i,
    input  logic                   ramp_done_i,
    output logic                   slow_en_o,
    output logic                   ramp_en_o,
    output logic [SDM_STAGE_W-1:0] sdm_stage_o,
    output logic [SDM_W-1:0]       sdm_act_o,
    output logic [N_W-1:0]         ndiv_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   timeout_o
);

    localparam int PRE_N_CYC    = us_to_cycles(CLK_MHZ, PRE_N_US);
    localparam int PRE_RAMP_CYC = us_to_cycles(CLK_MHZ, PRE_RAMP_US);
    localparam int RAMP_TMO_CYC = us_to_cycles(CLK_MHZ, RAMP_TMO_US);
    localparam int MAX_CYC      = (RAMP_TMO_CYC > PRE_N_CYC) ?
                                  ((RAMP_TMO_CYC > PRE_RAMP_CYC) ? RAMP_TMO_CYC : PRE_RAMP_CYC) :
                                  ((PRE_N_CYC > PRE_RAMP_CYC) ? PRE_N_CYC : PRE_RAMP_CYC);
    localparam int CNT_W        = $clog2(MAX_CYC + 1);

    initial begin
        assert (SDM_STAGE_W >= SDM_W && PRE_N_CYC > 0 && PRE_RAMP_CYC > 0 && RAMP_TMO_CYC > 0);
    end

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    pll_ndiv_ramp_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pll_ndiv_ramp_ctrl #(
        .N_W          (N_W),
        .SDM_W        (SDM_W),
        .SDM_STAGE_W  (SDM_STAGE_W),
        .CNT_W        (CNT_W),
        .PRE_N_CYC    (PRE_N_CYC),
        .PRE_RAMP_CYC (PRE_RAMP_CYC),
        .RAMP_TMO_CYC (RAMP_TMO_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tgt_n_i     (tgt_n_i),
        .tgt_sdm_i   (tgt_sdm_i),
        .cur_n_i     (cur_n_i),
        .cur_sdm_i   (cur_sdm_i),
        .ramp_done_i (ramp_done_i),
        .tmr_zero_i  (tmr_zero),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .slow_en_o   (slow_en_o),
        .ramp_en_o   (ramp_en_o),
        .sdm_stage_o (sdm_stage_o),
        .sdm_act_o   (sdm_act_o),
        .ndiv_o      (ndiv_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .timeout_o   (timeout_o)
    );

endmodule

// File: tb/pll_ndiv_ramp_seq_tb_top.sv
`timescale 1ns/1ps
module pll_ndiv_ramp_seq_tb_top;

    localparam int CLK_MHZ = 200;
    localparam int PRE_N_US = 1;
    localparam int PRE_RAMP_US = 1;
    localparam int RAMP_TMO_US = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  tgt_n_i = '0;
    logic [7:0]  tgt_sdm_i = '0;
    logic [7:0]  cur_n_i = '0;
    logic [7:0]  cur_sdm_i = '0;
    logic        ramp_done_i = 1'b0;
    logic        slow_en_o, ramp_en_o, busy_o, done_o, timeout_o;
    logic [14:0] sdm_stage_o;
    logic [7:0]  sdm_act_o, ndiv_o;

    int n_chk = 0;
    int n_fail = 0;
    int k = 0;
    logic [7:0]  model_n = '0;
    logic [7:0]  model_sdm = '0;
    logic [14:0] model_stage = '0;

    always #2.5 clk = ~clk;

    pll_ndiv_ramp_seq #(
        .CLK_MHZ     (CLK_MHZ),
        .PRE_N_US    (PRE_N_US),
        .PRE_RAMP_US (PRE_RAMP_US),
        .RAMP_TMO_US (RAMP_TMO_US)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tgt_n_i(tgt_n_i), .tgt_sdm_i(tgt_sdm_i),
        .cur_n_i(cur_n_i), .cur_sdm_i(cur_sdm_i),
        .ramp_done_i(ramp_done_i),
        .slow_en_o(slow_en_o), .ramp_en_o(ramp_en_o),
        .sdm_stage_o(sdm_stage_o), .sdm_act_o(sdm_act_o),
        .ndiv_o(ndiv_o), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    function automatic int t_pre_n();    return CLK_MHZ * PRE_N_US;    endfunction
    function automatic int t_pre_ramp(); return CLK_MHZ * PRE_RAMP_US; endfunction
    function automatic int t_tmo();      return CLK_MHZ * RAMP_TMO_US; endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic step_to(input int target);
        while (k < target) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_seq(input logic [7:0] n, input logic [7:0] s, input int dly,
                           input bit tmo_case, input bit poke_busy);
        logic [7:0] old_n;
        logic [7:0] old_s;
        int t1, t2, base;
        old_n = model_n;
        old_s = model_sdm;
        if (n == old_n && s == old_s) s = s ^ 8'h01;
        t1 = t_pre_n();
        t2 = t_pre_ramp();
        cur_n_i = old_n;
        cur_sdm_i = old_s;
        @(negedge clk);
        tgt_n_i = n; tgt_sdm_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        chk_eq("R3", "slowdown after start", int'(slow_en_o), 1);
        chk_eq("R3", "staging sdm", int'(sdm_stage_o), int'(s));
        chk_eq("R3", "active sdm unchanged", int'(sdm_act_o), int'(old_s));
        chk_eq("R8", "busy after start", int'(busy_o), 1);
        chk_eq("R7", "timeout cleared by start", int'(timeout_o), 0);
        if (poke_busy) begin
            tgt_n_i = ~n; tgt_sdm_i = ~s; cur_n_i = ~n; cur_sdm_i = ~s;
            start_i = 1'b1;
            step_to(1);
            start_i = 1'b0;
            chk_eq("R8", "busy start no done", int'(done_o), 0);
        end
        step_to(t1 - 1);
        chk_eq("R4", "n before wait end", int'(ndiv_o), int'(old_n));
        step_to(t1);
        chk_eq("R4", "n written", int'(ndiv_o), int'(n));
        chk_eq("R4", "no ramp at n write", int'(ramp_en_o), 0);
        step_to(t1 + t2 - 1);
        chk_eq("R5", "ramp before wait end", int'(ramp_en_o), 0);
        step_to(t1 + t2);
        chk_eq("R5", "ramp enabled", int'(ramp_en_o), 1);
        if (!tmo_case) begin
            step_to(t1 + t2 + dly);
            ramp_done_i = 1'b1;
            base = t1 + t2 + dly;
        end else begin
            step_to(t1 + t2 + t_tmo() - 1);
            chk_eq("R7", "no timeout yet", int'(timeout_o), 0);
            chk_eq("R7", "sdm held before timeout", int'(sdm_act_o), int'(old_s));
            base = t1 + t2 + t_tmo() - 1;
        end
        step_to(base + 1);
        chk_eq("R6", "active sdm committed", int'(sdm_act_o), int'(s));
        chk_eq("R6", "slowdown held at commit", int'(slow_en_o), 1);
        chk_eq("R6", "no done at commit", int'(done_o), 0);
        chk_eq("R7", "timeout flag", int'(timeout_o), tmo_case ? 1 : 0);
        step_to(base + 2);
        ramp_done_i = 1'b0;
        chk_eq("R6", "slowdown cleared", int'(slow_en_o), 0);
        chk_eq("R6", "ramp cleared", int'(ramp_en_o), 0);
        chk_eq("R6", "done pulse", int'(done_o), 1);
        chk_eq("R8", "busy cleared", int'(busy_o), 0);
        step_to(base + 3);
        chk_eq("R9", "done one cycle", int'(done_o), 0);
        chk_eq("R8", "final n is first target", int'(ndiv_o), int'(n));
        chk_eq("R8", "final sdm is first target", int'(sdm_act_o), int'(s));
        if (tmo_case) chk_eq("R7", "timeout sticky", int'(timeout_o), 1);
        model_n = n;
        model_sdm = s;
        model_stage = {7'd0, s};
    endtask

    task automatic run_skip();
        cur_n_i = model_n;
        cur_sdm_i = model_sdm;
        @(negedge clk);
        tgt_n_i = model_n; tgt_sdm_i = model_sdm; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk_eq("R2", "skip done", int'(done_o), 1);
        chk_eq("R2", "skip slowdown", int'(slow_en_o), 0);
        chk_eq("R2", "skip busy", int'(busy_o), 0);
        chk_eq("R7", "skip clears timeout", int'(timeout_o), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!slow_en_o && !ramp_en_o && !done_o, "R2", "controls quiet", int'(slow_en_o), 0);
        end
        chk_eq("R2", "skip n kept", int'(ndiv_o), int'(model_n));
        chk_eq("R2", "skip sdm kept", int'(sdm_act_o), int'(model_sdm));
        chk_eq("R2", "skip stage kept", int'(sdm_stage_o), int'(model_stage));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk_eq("R1", "reset slowdown", int'(slow_en_o), 0);
        chk_eq("R1", "reset ramp", int'(ramp_en_o), 0);
        chk_eq("R1", "reset busy", int'(busy_o), 0);
        chk_eq("R1", "reset done", int'(done_o), 0);
        chk_eq("R1", "reset timeout", int'(timeout_o), 0);
        chk_eq("R1", "reset n", int'(ndiv_o), 0);
        chk_eq("R1", "reset sdm", int'(sdm_act_o), 0);
        chk_eq("R1", "reset stage", int'(sdm_stage_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_skip();
        run_seq(8'd40, 8'h80, 0, 1'b0, 1'b0);
        run_seq(8'd40, 8'h7f, 3, 1'b0, 1'b1);
        run_seq(8'd255, 8'hff, t_tmo() - 1, 1'b0, 1'b0);
        run_seq(8'd12, 8'h00, 0, 1'b1, 1'b0);
        run_skip();
        run_seq(8'd8, 8'h01, 1, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) begin
            run_seq(8'($urandom_range(8, 255)), 8'($urandom), int'($urandom_range(0, 40)),
                    1'b0, ($urandom_range(0, 3) == 0));
            if ((i % 7) == 3) run_skip();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule